// File: doc/BRIEF.md
# Interrupt Destination Bitmask Resolver

This block turns an inter-processor interrupt command into the set of local interrupt controllers that should receive it. Up to `N_AGENTS` controllers sit in fixed slots. The physical ID of each controller is its slot index. Each slot also holds a logical address byte, a model nibble that picks flat or cluster logical matching, and an arbitration ID. A command carries these fields:

- an 8-bit destination
- a physical/logical select
- a two-bit shorthand
- the sender's ID
- a delivery mode
- the level and trigger bits

The block resolves the command combinationally. It registers the target bitmask and, for lowest-priority delivery, the single chosen slot. Both appear one cycle after the command strobe.

INIT commands also act on the slot state held here. A plain INIT returns the logical byte and the model nibble of every target to their defaults. An INIT with level 0 and trigger 1 leaves that state alone and instead loads each target's arbitration ID from its physical ID. A simple write port programs the logical byte and model nibble of one slot. All slot state is visible on output buses.

Top module: `ipi_dest_resolver`

## Requirements
- R1: With shorthand 1 the mask holds only the slot whose index equals `sender_i`, provided that slot is populated.
- R2: Shorthand 2 targets every populated slot. Shorthand 3 targets every populated slot except the one equal to `sender_i`.
- R3: With shorthand 0 and `logical_i`=0, destination 0xFF targets every populated slot. Any other destination targets only the slot whose index equals it.
- R4: With shorthand 0 and `logical_i`=1, a slot with model 0xF matches when `dest_i` AND its logical byte is nonzero.
- R5: With shorthand 0 and `logical_i`=1, a slot with model 0x0 matches when `dest_i[7:4]` equals its logical byte's bits [7:4] and the AND of bits [3:0] is nonzero. Any other model value never matches.
- R6: Slots with index not below `num_active_i` never appear in the mask, broadcasts included.
- R7: `out_valid_o`, `mask_o`, `lp_valid_o` and `lp_sel_o` reflect the command sampled at the previous rising edge. They are all zero when no command was sampled there.
- R8: For delivery mode 1, `lp_valid_o` is set when the mask is nonzero and `lp_sel_o` is the lowest set index. For an empty mask `lp_valid_o` stays 0. `mask_o` always carries the full resolved mask.
- R9: A command with delivery mode 5, `level_i`=0 and `trig_i`=1 sets each target's arbitration ID to its index. It leaves the logical byte and model nibble untouched.
- R10: Any other command with delivery mode 5 sets each target's logical byte to 0 and model to 0xF. Non-targets keep their state, and the reset wins over a same-cycle write to that slot.
- R11: After reset, every logical byte is 0, every model is 0xF, every arbitration ID is 0 and all command outputs are 0.
- R12: With `cfg_we_i` high, the slot `cfg_agent_i` takes `cfg_ldest_i` and `cfg_model_i` at the clock edge. The new values are seen by later commands, not by a command in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command strobe |
| dest_i | input | 8 | Destination field |
| logical_i | input | 1 | 1 = logical addressing, 0 = physical |
| shorthand_i | input | 2 | 0 dest field, 1 self, 2 all, 3 all but self |
| sender_i | input | 8 | Sender physical ID |
| dmode_i | input | 3 | Delivery mode (1 lowest priority, 5 INIT) |
| level_i | input | 1 | Level bit of the command |
| trig_i | input | 1 | Trigger bit of the command |
| num_active_i | input | $clog2(N_AGENTS+1) | Number of populated slots |
| cfg_we_i | input | 1 | Slot configuration write |
| cfg_agent_i | input | $clog2(N_AGENTS) | Slot written |
| cfg_ldest_i | input | 8 | Logical byte written |
| cfg_model_i | input | 4 | Model nibble written |
| out_valid_o | output | 1 | Registered command valid |
| mask_o | output | N_AGENTS | Resolved target mask |
| lp_valid_o | output | 1 | Lowest-priority pick valid |
| lp_sel_o | output | $clog2(N_AGENTS) | Lowest-priority slot |
| arb_id_o | output | 8*N_AGENTS | Arbitration IDs, slot i at [8i+7:8i] |
| ldest_o | output | 8*N_AGENTS | Logical bytes, slot i at [8i+7:8i] |
| model_o | output | 4*N_AGENTS | Model nibbles, slot i at [4i+3:4i] |

## Verification
Directed commands come first:

- Physical addressing with a plain ID, with 0xFF and with an ID that no slot has, which separates exact match from broadcast and from no match.
- Logical addressing over a mix of flat, cluster and invalid models, which shows whether the model nibble picks the right rule per slot.
- Each shorthand, rerun with fewer populated slots and a sender outside them, which separates the shorthand override from population masking.
- Lowest-priority commands with full and empty masks, and INIT and INIT-deassert commands with a clashing configuration write in the same cycle, which expose the pick and the state update order.

A long pseudo-random mix then checks every output and all slot state on every clock against a behavioural model.

// File: rtl/ipi_dest_pkg.sv
package ipi_dest_pkg;
  typedef enum logic [1:0] {
    SH_DEST   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  localparam logic [2:0] DM_LOWEST = 3'd1;
  localparam logic [2:0] DM_INIT   = 3'd5;

  localparam logic [3:0] MODEL_FLAT    = 4'hF;
  localparam logic [3:0] MODEL_CLUSTER = 4'h0;

  localparam logic [7:0] DEST_BCAST = 8'hFF;

  typedef struct packed {
    logic [7:0] ldest;
    logic [3:0] model;
    logic [7:0] arb;
  } slot_t;
endpackage

// File: rtl/ipi_slot_match.sv
module ipi_slot_match
  import ipi_dest_pkg::*;
#(
  parameter int SLOT_ID = 0
) (
  input  logic [7:0] dest_i,
  input  logic       logical_i,
  input  logic [1:0] shorthand_i,
  input  logic [7:0] sender_i,
  input  logic [7:0] ldest_i,
  input  logic [3:0] model_i,
  input  logic       present_i,
  output logic       hit_o
);
  localparam logic [7:0] MY_ID = 8'(SLOT_ID);

  logic addr_hit;
  logic sel_hit;

  always_comb begin
    if (!logical_i) begin
      addr_hit = (dest_i == DEST_BCAST) || (dest_i == MY_ID);
    end else begin
      unique case (model_i)
        MODEL_FLAT:    addr_hit = |(dest_i & ldest_i);
        MODEL_CLUSTER: addr_hit = (dest_i[7:4] == ldest_i[7:4]) &&
                                  (|(dest_i[3:0] & ldest_i[3:0]));
        default:       addr_hit = 1'b0;
      endcase
    end
  end

  always_comb begin
    unique case (shorthand_e'(shorthand_i))
      SH_DEST:   sel_hit = addr_hit;
      SH_SELF:   sel_hit = (sender_i == MY_ID);
      SH_ALL:    sel_hit = 1'b1;
      SH_OTHERS: sel_hit = (sender_i != MY_ID);
      default:   sel_hit = 1'b0;
    endcase
  end

  assign hit_o = present_i & sel_hit;
endmodule

// File: rtl/ipi_first_set.sv
module ipi_first_set #(
  parameter int W     = 8,
  parameter int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     vec_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    // scan down so the lowest set index is written last
    for (int k = W - 1; k >= 0; k--) begin
      if (vec_i[k]) idx_o = IDX_W'(k);
    end
  end

  assign any_o = |vec_i;
endmodule

// File: rtl/ipi_dest_resolver.sv
module ipi_dest_resolver
  import ipi_dest_pkg::*;
#(
  parameter  int N_AGENTS = 8,
  localparam int IDX_W    = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1,
  localparam int CNT_W    = $clog2(N_AGENTS + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cmd_valid_i,
  input  logic [7:0]            dest_i,
  input  logic                  logical_i,
  input  logic [1:0]            shorthand_i,
  input  logic [7:0]            sender_i,
  input  logic [2:0]            dmode_i,
  input  logic                  level_i,
  input  logic                  trig_i,
  input  logic [CNT_W-1:0]      num_active_i,
  input  logic                  cfg_we_i,
  input  logic [IDX_W-1:0]      cfg_agent_i,
  input  logic [7:0]            cfg_ldest_i,
  input  logic [3:0]            cfg_model_i,
  output logic                  out_valid_o,
  output logic [N_AGENTS-1:0]   mask_o,
  output logic                  lp_valid_o,
  output logic [IDX_W-1:0]      lp_sel_o,
  output logic [8*N_AGENTS-1:0] arb_id_o,
  output logic [8*N_AGENTS-1:0] ldest_o,
  output logic [4*N_AGENTS-1:0] model_o
);
  slot_t [N_AGENTS-1:0] slot_q;
  logic  [N_AGENTS-1:0] hit;
  logic                 pick_any;
  logic [IDX_W-1:0]     pick_idx;
  logic                 is_init;
  logic                 init_deassert;
  logic                 init_reset;

  assign is_init       = cmd_valid_i && (dmode_i == DM_INIT);
  assign init_deassert = is_init && !level_i && trig_i;
  assign init_reset    = is_init && !(!level_i && trig_i);

  for (genvar i = 0; i < N_AGENTS; i++) begin : g_slot
    logic present;
    assign present = (CNT_W'(i) < num_active_i);

    ipi_slot_match #(.SLOT_ID(i)) u_match (
      .dest_i      (dest_i),
      .logical_i   (logical_i),
      .shorthand_i (shorthand_i),
      .sender_i    (sender_i),
      .ldest_i     (slot_q[i].ldest),
      .model_i     (slot_q[i].model),
      .present_i   (present),
      .hit_o       (hit[i])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_q[i].ldest <= '0;
        slot_q[i].model <= MODEL_FLAT;
        slot_q[i].arb   <= '0;
      end else begin
        if (init_reset && hit[i]) begin
          slot_q[i].ldest <= '0;
          slot_q[i].model <= MODEL_FLAT;
        end else if (cfg_we_i && (cfg_agent_i == IDX_W'(i))) begin
          slot_q[i].ldest <= cfg_ldest_i;
          slot_q[i].model <= cfg_model_i;
        end
        if (init_deassert && hit[i]) slot_q[i].arb <= 8'(i);
      end
    end

    assign arb_id_o[8*i +: 8] = slot_q[i].arb;
    assign ldest_o[8*i +: 8]  = slot_q[i].ldest;
    assign model_o[4*i +: 4]  = slot_q[i].model;
  end

  ipi_first_set #(.W(N_AGENTS), .IDX_W(IDX_W)) u_pick (
    .vec_i (hit),
    .any_o (pick_any),
    .idx_o (pick_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      mask_o      <= '0;
      lp_valid_o  <= 1'b0;
      lp_sel_o    <= '0;
    end else begin
      out_valid_o <= cmd_valid_i;
      mask_o      <= cmd_valid_i ? hit : '0;
      lp_valid_o  <= cmd_valid_i && (dmode_i == DM_LOWEST) && pick_any;
      lp_sel_o    <= (cmd_valid_i && (dmode_i == DM_LOWEST)) ? pick_idx : '0;
    end
  end
endmodule

// File: rtl/ipi_dest_resolver_chk.sv
module ipi_dest_resolver_chk
  import ipi_dest_pkg::*;
#(
  parameter  int N_AGENTS = 8,
  localparam int IDX_W    = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1,
  localparam int CNT_W    = $clog2(N_AGENTS + 1)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  cmd_valid_i,
  input logic [1:0]            shorthand_i,
  input logic [2:0]            dmode_i,
  input logic                  level_i,
  input logic                  trig_i,
  input logic [CNT_W-1:0]      num_active_i,
  input logic                  out_valid_o,
  input logic [N_AGENTS-1:0]   mask_o,
  input logic                  lp_valid_o,
  input logic [IDX_W-1:0]      lp_sel_o,
  input logic [8*N_AGENTS-1:0] arb_id_o,
  input logic [8*N_AGENTS-1:0] ldest_o,
  input logic [4*N_AGENTS-1:0] model_o
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> (out_valid_o == $past(cmd_valid_i))); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> (mask_o == '0 && !lp_valid_o)); // R7

  AST_POP_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && out_valid_o) |->
      ((mask_o >> $past(num_active_i)) == '0)); // R6

  AST_SELF_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && out_valid_o && $past(shorthand_i) == 2'd1) |->
      ($countones(mask_o) <= 1)); // R1

  AST_LP_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lp_valid_o |-> (mask_o[lp_sel_o] &&
      ((mask_o & ((N_AGENTS'(1) << lp_sel_o) - N_AGENTS'(1))) == '0))); // R8

  AST_LP_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && out_valid_o && $past(dmode_i) == DM_LOWEST) |->
      (lp_valid_o == (mask_o != '0))); // R8

  for (genvar i = 0; i < N_AGENTS; i++) begin : g_chk
    AST_INIT_DEFAULTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed && mask_o[i] && $past(cmd_valid_i && dmode_i == DM_INIT &&
                                   !(!level_i && trig_i))) |->
        (ldest_o[8*i +: 8] == 8'h00 && model_o[4*i +: 4] == MODEL_FLAT)); // R10

    AST_ARB_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed && mask_o[i] && $past(cmd_valid_i && dmode_i == DM_INIT &&
                                   !level_i && trig_i)) |->
        (arb_id_o[8*i +: 8] == 8'(i))); // R9
  end
endmodule

bind ipi_dest_resolver ipi_dest_resolver_chk #(.N_AGENTS(N_AGENTS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_valid_i  (cmd_valid_i),
  .shorthand_i  (shorthand_i),
  .dmode_i      (dmode_i),
  .level_i      (level_i),
  .trig_i       (trig_i),
  .num_active_i (num_active_i),
  .out_valid_o  (out_valid_o),
  .mask_o       (mask_o),
  .lp_valid_o   (lp_valid_o),
  .lp_sel_o     (lp_sel_o),
  .arb_id_o     (arb_id_o),
  .ldest_o      (ldest_o),
  .model_o      (model_o)
);

// File: tb/tb_ipi_dest_resolver.sv
module tb_ipi_dest_resolver;
  localparam int N     = 8;
  localparam int IDX_W = 3;
  localparam int CNT_W = 4;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cmd_valid_i = 1'b0;
  logic [7:0]       dest_i = '0;
  logic             logical_i = 1'b0;
  logic [1:0]       shorthand_i = '0;
  logic [7:0]       sender_i = '0;
  logic [2:0]       dmode_i = '0;
  logic             level_i = 1'b0;
  logic             trig_i = 1'b0;
  logic [CNT_W-1:0] num_active_i = CNT_W'(N);
  logic             cfg_we_i = 1'b0;
  logic [IDX_W-1:0] cfg_agent_i = '0;
  logic [7:0]       cfg_ldest_i = '0;
  logic [3:0]       cfg_model_i = '0;
  logic             out_valid_o;
  logic [N-1:0]     mask_o;
  logic             lp_valid_o;
  logic [IDX_W-1:0] lp_sel_o;
  logic [8*N-1:0]   arb_id_o;
  logic [8*N-1:0]   ldest_o;
  logic [4*N-1:0]   model_o;

  ipi_dest_resolver #(.N_AGENTS(N)) dut (.*);

  always #2 clk_i = ~clk_i;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int m_ldest[N];
  int m_model[N];
  int m_arb[N];

  function automatic bit ref_hit(int i);
    int d = dest_i;
    int s = sender_i;
    bit a;
    if (i >= num_active_i) return 0;
    case (shorthand_i)
      2'd1: return s == i;
      2'd2: return 1;
      2'd3: return s != i;
      default: ;
    endcase
    if (!logical_i) return (d == 255) || (d == i);
    if (m_model[i] == 15) a = (d & m_ldest[i]) != 0;
    else if (m_model[i] == 0)
      a = ((d / 16) == (m_ldest[i] / 16)) && (((d % 16) & (m_ldest[i] % 16)) != 0);
    else a = 0;
    return a;
  endfunction

  function automatic logic [8*N-1:0] pack8(int v[N]);
    logic [8*N-1:0] r;
    for (int i = 0; i < N; i++) r[8*i +: 8] = 8'(v[i]);
    return r;
  endfunction

  function automatic logic [4*N-1:0] pack4(int v[N]);
    logic [4*N-1:0] r;
    for (int i = 0; i < N; i++) r[4*i +: 4] = 4'(v[i]);
    return r;
  endfunction

  task automatic check_state(string tag);
    checks++;
    if (ldest_o !== pack8(m_ldest) || model_o !== pack4(m_model) ||
        arb_id_o !== pack8(m_arb)) begin
      errors++;
      $display("FAIL %s state: ldest=%h/%h model=%h/%h arb=%h/%h (got/exp)", tag,
               ldest_o, pack8(m_ldest), model_o, pack4(m_model), arb_id_o, pack8(m_arb));
    end
  endtask

  // one clock: predict, step, compare, commit model, clear strobes
  task automatic tick(string tag);
    logic [N-1:0] em;
    bit elp_v;
    int elp_s;
    bit ev;
    em = '0;
    for (int i = 0; i < N; i++) em[i] = cmd_valid_i && ref_hit(i);
    ev = cmd_valid_i;
    elp_v = 0;
    elp_s = 0;
    if (cmd_valid_i && dmode_i == 3'd1) begin
      for (int i = N - 1; i >= 0; i--) if (em[i]) begin elp_v = 1; elp_s = i; end
    end
    if (cfg_we_i) begin
      m_ldest[cfg_agent_i] = cfg_ldest_i;
      m_model[cfg_agent_i] = cfg_model_i;
    end
    if (cmd_valid_i && dmode_i == 3'd5) begin
      for (int i = 0; i < N; i++) if (em[i]) begin
        if (!level_i && trig_i) m_arb[i] = i;
        else begin m_ldest[i] = 0; m_model[i] = 15; end
      end
    end
    @(posedge clk_i);
    #1;
    checks++;
    if (out_valid_o !== ev || mask_o !== em || lp_valid_o !== elp_v ||
        lp_sel_o !== IDX_W'(elp_s)) begin
      errors++;
      $display("FAIL %s out: v=%b mask=%b lp=%b/%0d exp v=%b mask=%b lp=%b/%0d", tag,
               out_valid_o, mask_o, lp_valid_o, lp_sel_o, ev, em, elp_v, elp_s);
    end
    check_state(tag);
    cmd_valid_i = 0;
    cfg_we_i = 0;
  endtask

  task automatic cmd(input logic [7:0] d, input logic lg, input logic [1:0] sh,
                     input logic [7:0] snd, input logic [2:0] dm,
                     input logic lv, input logic tg);
    cmd_valid_i = 1; dest_i = d; logical_i = lg; shorthand_i = sh;
    sender_i = snd; dmode_i = dm; level_i = lv; trig_i = tg;
  endtask

  task automatic cfg(input int a, input int ld, input int md);
    cfg_we_i = 1; cfg_agent_i = IDX_W'(a); cfg_ldest_i = 8'(ld); cfg_model_i = 4'(md);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not end, got timeout exp completion");
    finish_run();
  end

  initial begin
    logic [31:0] seed;
    string t;
    for (int i = 0; i < N; i++) begin m_ldest[i] = 0; m_model[i] = 15; m_arb[i] = 0; end
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    @(negedge clk_i);
    // R11 reset state
    checks++;
    if (out_valid_o !== 0 || mask_o !== '0 || lp_valid_o !== 0 || lp_sel_o !== '0) begin
      errors++;
      $display("FAIL R11 outputs: v=%b mask=%b lp=%b got, exp all 0", out_valid_o, mask_o, lp_valid_o);
    end
    check_state("R11");
    @(posedge clk_i); #1;

    // R12 program slots: 0-3 flat, 4-6 cluster, 7 invalid model
    cfg(0, 8'h01, 15); tick("R12");
    cfg(1, 8'h02, 15); tick("R12");
    cfg(2, 8'h04, 15); tick("R12");
    cfg(3, 8'h0C, 15); tick("R12");
    cfg(4, 8'h21, 0);  tick("R12");
    cfg(5, 8'h23, 0);  tick("R12");
    cfg(6, 8'h31, 0);  tick("R12");
    cfg(7, 8'hFF, 5);  tick("R12");
    // R12 same-cycle write not seen by command
    cmd(8'h80, 1, 0, 0, 0, 0, 0); cfg(0, 8'h80, 15); tick("R12");
    cmd(8'h80, 1, 0, 0, 0, 0, 0); tick("R12");
    cfg(0, 8'h01, 15); tick("R12");

    cmd(8'h03, 0, 0, 0, 0, 0, 0); tick("R3");
    cmd(8'hFF, 0, 0, 0, 0, 0, 0); tick("R3");
    cmd(8'h09, 0, 0, 0, 0, 0, 0); tick("R3");
    cmd(8'h05, 1, 0, 0, 0, 0, 0); tick("R4");
    cmd(8'h0A, 1, 0, 0, 0, 0, 0); tick("R4");
    cmd(8'h21, 1, 0, 0, 0, 0, 0); tick("R5");
    cmd(8'h32, 1, 0, 0, 0, 0, 0); tick("R5");
    cmd(8'h31, 1, 0, 0, 0, 0, 0); tick("R5");
    cmd(8'h00, 0, 1, 2, 0, 0, 0); tick("R1");
    cmd(8'h00, 0, 2, 0, 0, 0, 0); tick("R2");
    cmd(8'h00, 0, 3, 4, 0, 0, 0); tick("R2");
    tick("R7");
    num_active_i = 5;
    cmd(8'h00, 0, 2, 0, 0, 0, 0); tick("R6");
    cmd(8'hFF, 0, 0, 0, 0, 0, 0); tick("R6");
    cmd(8'h00, 0, 1, 6, 0, 0, 0); tick("R6");
    cmd(8'h00, 0, 3, 1, 0, 0, 0); tick("R6");
    num_active_i = 8;
    cmd(8'h0C, 1, 0, 0, 1, 0, 0); tick("R8");
    cmd(8'h00, 0, 3, 0, 1, 0, 0); tick("R8");
    cmd(8'h40, 1, 0, 0, 1, 0, 0); tick("R8");
    cmd(8'hFF, 0, 0, 0, 1, 0, 0); tick("R8");
    cmd(8'h00, 0, 2, 0, 5, 0, 1); tick("R9");
    tick("R9");
    cmd(8'h04, 0, 0, 0, 5, 1, 0); cfg(4, 8'h55, 0); tick("R10");
    cfg(1, 8'h66, 0); cmd(8'h02, 0, 0, 0, 5, 1, 1); tick("R10");
    tick("R10");

    seed = 32'h1234_5678;
    for (int n = 0; n < 3000; n++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      num_active_i = CNT_W'((seed[3:0] % 9 < 3) ? seed[7:4] % 9 : 8);
      if (seed[8]) cfg(seed[11:9], {seed[12], seed[13], 2'b0, seed[14], seed[15], seed[16], seed[17]},
                       seed[18] ? 15 : (seed[19] ? 0 : 4'(seed[23:20])));
      seed = seed * 32'd1664525 + 32'd1013904223;
      if (seed[0] | seed[1]) begin
        cmd({seed[31:28], seed[13:10]}, seed[2], seed[4:3] & {seed[5], 1'b1}, 8'(seed[8:6]),
            seed[9] ? 3'd1 : (seed[14] && seed[15] ? 3'd5 : 3'd0), seed[16], seed[17]);
        if (seed[18]) sender_i = 8'(seed[26:19]);
      end
      if (!cmd_valid_i) t = "R7";
      else if (dmode_i == 3'd5) t = (!level_i && trig_i) ? "R9" : "R10";
      else if (dmode_i == 3'd1) t = "R8";
      else if (shorthand_i == 2'd1) t = "R1";
      else if (shorthand_i != 2'd0) t = "R2";
      else if (logical_i) t = "R5";
      else t = "R3";
      tick(t);
    end
    finish_run();
  end
endmodule